// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Unit

This unit collects the single-cycle event pulses of a flash controller into a sticky event register. It combines that register with a mask to drive one level-high interrupt line. Software reads the event register through a small register port, and the read clears every flag it returns. A second, live status view reports the present ready levels and the result of the last ECC decode, including a two-bit corrected-symbol count. A combined device-ready signal is high while both the flash and the controller report ready.

The interrupt line is produced by a two-state machine. In `IRQ_QUIET` the line is low. The transition *raise* moves it to `IRQ_RAISED` on the clock edge after any unmasked flag is seen set. In `IRQ_RAISED` the line is high. The transition *drop* returns it to `IRQ_QUIET` on the clock edge after no unmasked flag remains. The register port is combinational on reads: data for the selected register appears in the same cycle as the request, and the clear takes effect at the closing clock edge.

Register select codes: 0 = event register, 1 = mask register, 2 = live status, 3 = unused.

Top module: `flash_irq_status`

## Requirements
- R1: `evt_pulse[i]` high at a clock edge sets event flag i at that edge. The bit order is: 0 write-protect fault, 1 ECC ready, 2 decode error, 3 decode failure, 4 controller ready, 5 flash ready. The same order holds in the mask register and in bits 5:0 of the event read data.
- R2: A read with select 0 returns the event flags as they stood before the edge, zero-extended to 8 bits. That edge clears every flag that was set.
- R3: An event pulse in the same cycle as a clearing read leaves its flag set after the edge.
- R4: `irq` is high on the cycle after `event flags AND mask` is non-zero, and low on the cycle after it is zero.
- R5: Mask bits affect only `irq`. Masked events still latch and read back.
- R6: A write with select 1 loads the mask from `reg_wdata`. A read with select 1 returns it, and no other access changes it.
- R7: A read with select 2 returns the live status. Bit 0 is flash ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 the error-count field, bit 6 decoder failure, and bit 7 is zero. Reading it changes nothing, and it follows its inputs in the same cycle.
- R8: The error-count field is `err_count - 1` when `err_found` is high and `err_count` is 1 to 4. It saturates at 3 above 4, and it is 0 when `err_found` is low or `err_count` is 0.
- R9: `dev_ready` is high exactly when `flash_rdy` and `ctrl_rdy` are both high.
- R10: After reset the mask is zero, all event flags are clear and `irq` is low.
- R11: Writes with select 0, 2 or 3 change no state. Reads with select 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 6 | Event pulses, bit order per R1 |
| flash_rdy | input | 1 | Live flash-ready level |
| ctrl_rdy | input | 1 | Live controller-ready level |
| ecc_rdy | input | 1 | Live ECC-ready level |
| err_found | input | 1 | Last decode corrected errors |
| err_count | input | 3 | Number of corrected symbols |
| dec_fail | input | 1 | Last decode was uncorrectable |
| reg_sel | input | 2 | Register select |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Level-high interrupt |
| dev_ready | output | 1 | Flash and controller both ready |

## Verification
The bench fires an event in the same cycle as a clearing read. A unit whose clear takes priority over the set would lose that event for good. It checks the interrupt timing cycle by cycle and toggles the mask while events are pending. A unit that gated latching with the mask would make masked events vanish, and one that sampled stale state would be late or early by a cycle. It sweeps the error count across 0 to 5 with `err_found` on and off, which exposes an off-by-one count field or missing saturation. It also writes to read-only and unused selects, which catches a decoder that lets those accesses touch the mask or the flags.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int EVT_N  = 6;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;
    localparam int CNT_W  = 3;

    // Event bit positions, shared by flags and mask
    localparam int EV_WP_FAULT   = 0;
    localparam int EV_ECC_READY  = 1;
    localparam int EV_DEC_ERROR  = 2;
    localparam int EV_DEC_FAIL   = 3;
    localparam int EV_CTRL_READY = 4;
    localparam int EV_FLASH_RDY  = 5;

    typedef enum logic [SEL_W-1:0] {
        SEL_LATCH = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_LIVE  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic       dec_fail;
        logic [1:0] err_cnt;
        logic       err_found;
        logic       ecc_rdy;
        logic       ctrl_rdy;
        logic       flash_rdy;
    } live_t;

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    flags_o[g] <= 1'b0;
                else if (evt_i[g])
                    flags_o[g] <= 1'b1;   // set wins over clear
                else if (clr_i)
                    flags_o[g] <= 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_live_status.sv
module irq_live_status
    import flash_irq_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          flash_rdy_i,
    input  logic          ctrl_rdy_i,
    input  logic          ecc_rdy_i,
    input  logic          err_found_i,
    input  logic [CW-1:0] err_count_i,
    input  logic          dec_fail_i,
    output live_t         live_o,
    output logic          dev_ready_o
);

    localparam logic [CW-1:0] CNT_MAX = CW'(4);

    logic [CW-1:0] cnt_sat;
    logic [CW-1:0] cnt_less;

    always_comb begin
        cnt_sat  = (err_count_i > CNT_MAX) ? CNT_MAX : err_count_i;
        cnt_less = (err_found_i && cnt_sat != '0) ? (cnt_sat - CW'(1)) : '0;

        live_o.flash_rdy = flash_rdy_i;
        live_o.ctrl_rdy  = ctrl_rdy_i;
        live_o.ecc_rdy   = ecc_rdy_i;
        live_o.err_found = err_found_i;
        live_o.err_cnt   = cnt_less[1:0];
        live_o.dec_fail  = dec_fail_i;

        dev_ready_o = flash_rdy_i & ctrl_rdy_i;
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import flash_irq_pkg::*;
#(
    parameter int N  = EVT_N,
    parameter int DW = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [N-1:0]     wdata_i,
    input  logic [N-1:0]     flags_i,
    input  live_t            live_i,
    output logic [N-1:0]     mask_o,
    output logic             clr_o,
    output logic [DW-1:0]    rdata_o
);

    localparam int LW = $bits(live_t);

    reg_sel_e sel;
    assign sel = reg_sel_e'(sel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_o <= '0;
        else if (wr_i && sel == SEL_MASK)
            mask_o <= wdata_i;
    end

    assign clr_o = rd_i && (sel == SEL_LATCH);

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_LATCH: rdata_o[N-1:0]  = flags_i;
            SEL_MASK:  rdata_o[N-1:0]  = mask_o;
            SEL_LIVE:  rdata_o[LW-1:0] = live_i;
            SEL_NONE:  rdata_o         = '0;
        endcase
    end

endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import flash_irq_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);

    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = |(flags_i & mask_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_QUIET;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;  // raise
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;   // drop
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_N-1:0]  evt_pulse,
    input  logic              flash_rdy,
    input  logic              ctrl_rdy,
    input  logic              ecc_rdy,
    input  logic              err_found,
    input  logic [CNT_W-1:0]  err_count,
    input  logic              dec_fail,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [EVT_N-1:0]  reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              dev_ready
);

    logic [EVT_N-1:0] lat_flags;
    logic [EVT_N-1:0] mask_q;
    logic             clr;
    live_t            live;

    irq_event_latch #(.N(EVT_N)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_pulse),
        .clr_i   (clr),
        .flags_o (lat_flags)
    );

    irq_live_status #(.CW(CNT_W)) u_live (
        .flash_rdy_i (flash_rdy),
        .ctrl_rdy_i  (ctrl_rdy),
        .ecc_rdy_i   (ecc_rdy),
        .err_found_i (err_found),
        .err_count_i (err_count),
        .dec_fail_i  (dec_fail),
        .live_o      (live),
        .dev_ready_o (dev_ready)
    );

    irq_reg_port #(.N(EVT_N), .DW(DATA_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (reg_sel),
        .rd_i    (reg_rd),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .flags_i (lat_flags),
        .live_i  (live),
        .mask_o  (mask_q),
        .clr_o   (clr),
        .rdata_o (reg_rdata)
    );

    irq_line_fsm #(.N(EVT_N)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (lat_flags),
        .mask_i  (mask_q),
        .irq_o   (irq)
    );

endmodule

// File: rtl/flash_irq_status_chk.sv
module flash_irq_status_chk
    import flash_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [EVT_N-1:0]  evt_pulse,
    input logic              flash_rdy,
    input logic              ctrl_rdy,
    input logic              err_found,
    input logic [CNT_W-1:0]  err_count,
    input logic [SEL_W-1:0]  reg_sel,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              dev_ready,
    input logic [EVT_N-1:0]  lat_flags,
    input logic [EVT_N-1:0]  mask_q
);

    p_event_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=> ((lat_flags & $past(evt_pulse)) == $past(evt_pulse)));

    p_clear_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_LATCH) |=> (lat_flags == $past(evt_pulse)));

    p_keep_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == SEL_LATCH && evt_pulse != '0) |=> (lat_flags != '0));

    p_irq_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(lat_flags & mask_q)));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel == SEL_MASK) |=> $stable(mask_q));

    p_count_field_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_LIVE && err_found && err_count >= 3'd1 && err_count <= 3'd4)
        |-> (reg_rdata[5:4] == 2'(err_count - 3'd1)));

    p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ready |-> (flash_rdy && ctrl_rdy));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_NONE) |-> (reg_rdata == '0));

endmodule

bind flash_irq_status flash_irq_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .flash_rdy (flash_rdy),
    .ctrl_rdy  (ctrl_rdy),
    .err_found (err_found),
    .err_count (err_count),
    .reg_sel   (reg_sel),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .dev_ready (dev_ready),
    .lat_flags (lat_flags),
    .mask_q    (mask_q)
);

// File: tb/flash_irq_status_tb.sv
`timescale 1ns/1ps
module flash_irq_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt_pulse = '0;
    logic       flash_rdy = 0, ctrl_rdy = 0, ecc_rdy = 0, err_found = 0, dec_fail = 0;
    logic [2:0] err_count = '0;
    logic [1:0] reg_sel = '0;
    logic       reg_rd = 0, reg_wr = 0;
    logic [5:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, dev_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .flash_rdy(flash_rdy), .ctrl_rdy(ctrl_rdy), .ecc_rdy(ecc_rdy),
        .err_found(err_found), .err_count(err_count), .dec_fail(dec_fail),
        .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dev_ready(dev_ready)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk) evt_pulse = v;
        @(negedge clk) evt_pulse = '0;
    endtask

    // read: data sampled before the edge, strobe held through one edge
    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk) begin reg_sel = s; reg_rd = 1'b1; end
        #1 d = reg_rdata;
        @(negedge clk) reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [5:0] v);
        @(negedge clk) begin reg_sel = s; reg_wdata = v; reg_wr = 1'b1; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R10 irq after reset", {7'd0, irq}, 8'h00);
        rd(2'd1, d); chk("R10 mask after reset", d, 8'h00);
        rd(2'd0, d); chk("R10 flags after reset", d, 8'h00);
    endtask

    task automatic t_latch_order;
        logic [7:0] d;
        for (int i = 0; i < 6; i++) begin
            pulse(6'(1 << i));
            rd(2'd0, d);
            chk("R1 event bit position", d, 8'(1 << i));
        end
    endtask

    task automatic t_read_clear;
        logic [7:0] d;
        pulse(6'b101101);
        rd(2'd0, d); chk("R2 read returns flags", d, 8'h2D);
        rd(2'd0, d); chk("R2 flags cleared by read", d, 8'h00);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        pulse(6'b000010);
        @(negedge clk) begin reg_sel = 2'd0; reg_rd = 1'b1; evt_pulse = 6'b100000; end
        #1 d = reg_rdata;
        @(negedge clk) begin reg_rd = 1'b0; evt_pulse = '0; end
        chk("R2 pre-clear value", d, 8'h02);
        rd(2'd0, d); chk("R3 coincident event kept", d, 8'h20);
    endtask

    task automatic t_mask_irq;
        logic [7:0] d;
        pulse(6'b000100);
        @(negedge clk);
        chk("R5 masked event no irq", {7'd0, irq}, 8'h00);
        wr(2'd1, 6'b000100);
        rd(2'd1, d); chk("R6 mask readback", d, 8'h04);
        chk("R4 irq after unmask", {7'd0, irq}, 8'h01);
        rd(2'd0, d); chk("R5 masked event latched", d, 8'h04);
        chk("R4 irq one cycle after clear", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R4 irq dropped", {7'd0, irq}, 8'h00);
        wr(2'd1, 6'b010000);
        pulse(6'b010000);
        chk("R4 irq not yet high", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R4 irq raised", {7'd0, irq}, 8'h01);
        rd(2'd0, d);
        @(negedge clk);
        wr(2'd1, 6'b000000);
    endtask

    task automatic t_live;
        logic [7:0] d, d2;
        flash_rdy = 1; ctrl_rdy = 0; ecc_rdy = 1; err_found = 0; dec_fail = 1; err_count = 0;
        rd(2'd2, d); chk("R7 live pattern A", d, 8'h45);
        rd(2'd2, d2); chk("R7 live read has no effect", d2, d);
        flash_rdy = 0; ctrl_rdy = 1; ecc_rdy = 0; err_found = 1; dec_fail = 0; err_count = 3;
        rd(2'd2, d); chk("R7 live pattern B", d, 8'h2A);
        for (int c = 0; c < 6; c++) begin
            for (int e = 0; e < 2; e++) begin
                logic [1:0] f;
                err_found = e[0]; err_count = 3'(c);
                f = (e == 0 || c == 0) ? 2'd0 : ((c > 4) ? 2'd3 : 2'(c - 1));
                rd(2'd2, d);
                chk("R8 error count field", {6'd0, d[5:4]}, {6'd0, f});
            end
        end
        err_found = 0; err_count = 0;
    endtask

    task automatic t_ready;
        for (int k = 0; k < 4; k++) begin
            flash_rdy = k[0]; ctrl_rdy = k[1];
            #1 chk("R9 device ready", {7'd0, dev_ready}, {7'd0, (k == 3)});
        end
        flash_rdy = 0; ctrl_rdy = 0;
    endtask

    task automatic t_ignored;
        logic [7:0] d;
        wr(2'd1, 6'b001001);
        wr(2'd0, 6'b111111);
        wr(2'd2, 6'b111111);
        wr(2'd3, 6'b111111);
        rd(2'd0, d); chk("R11 write to flags ignored", d, 8'h00);
        rd(2'd1, d); chk("R11 mask untouched", d, 8'h09);
        rd(2'd3, d); chk("R11 unused select reads zero", d, 8'h00);
        chk("R11 no irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_order();
        t_read_clear();
        t_same_cycle();
        t_mask_irq();
        t_live();
        t_ready();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule